// File: doc/BRIEF.md
# Sync Presence and Display Power-State Detector

This block monitors a horizontal and a vertical sync input, each arriving separately. For each input it decides whether pulses are still arriving and which way they point. It then combines the two presence flags into one of four display power states. Firmware reads that state and uses it to enter or leave power saving. Both inputs are resampled into the local clock domain by a two-flop synchronizer before any edge is taken.

A sync input is present while its edges keep coming. It becomes absent once a programmable number of timebase ticks passes with no edge. The timebase is a single-cycle strobe, typically microsecond scale. Polarity comes from a run-length comparison: the block measures, in clock cycles, how long the input sat high and how long it sat low. Whichever level was held for the shorter time is taken to be the pulse. All results are packed into one read-only status word.

Top module: `sync_power_det`

## Requirements
- R1: After reset, status_o reads 8'h30. The status layout is: bit 0 horizontal present, bit 1 vertical present, bit 2 horizontal polarity, bit 3 vertical polarity, bits 5:4 power state, bits 7:6 zero.
- R2: A level change on a sync input sets that input's present bit on the third rising clock edge after the change, and not earlier.
- R3: A present input stays present through limit-1 ticks with no edge, and turns absent on the limit-th such tick.
- R4: When an edge and the expiring tick fall in the same cycle, the edge wins. The input stays present and its timeout restarts from zero.
- R5: The power state is encoded as follows: 2'b00 when both inputs are present (normal), 2'b01 when vertical is present and horizontal is absent (standby), 2'b10 when horizontal is present and vertical is absent (suspend), and 2'b11 when both are absent (off).
- R6: The polarity bit of a present input reads 1 when its high runs are shorter than its low runs, and 0 otherwise. It is updated only at an edge, and only once one high run and one low run have both been measured since the input became present.
- R7: When an input turns absent, its polarity bit keeps the last value it decided.
- R8: Presence and polarity of each input depend only on that input's own activity and its own limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| h_limit_i | input | TO_W | Horizontal absence timeout, in ticks |
| v_limit_i | input | TO_W | Vertical absence timeout, in ticks |
| status_o | output | 8 | Presence bits, polarity bits and power state |

## Verification
Two functions can land in the same cycle: a synchronized edge on an input, and the tick that would expire that input's timeout. The bench provokes this on purpose. It first runs limit-1 ticks, then places a toggle exactly two clock edges ahead of one more tick, so the edge and the expiring tick reach the presence register together. The result is judged at the ports. The present bit must stay set, and absence must then take a full limit of further ticks, counted one tick at a time.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'b00,
    PWR_STANDBY = 2'b01,
    PWR_SUSPEND = 2'b10,
    PWR_OFF     = 2'b11
  } pwr_state_e;

  localparam int unsigned CH_H   = 0;
  localparam int unsigned CH_V   = 1;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/sync_det_sync2.sv
module sync_det_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sync_det_presence.sv
module sync_det_presence #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            lvl_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            rise_o,
  output logic            fall_o,
  output logic            present_o
);
  localparam logic [TO_W:0] CNT_ONE = {{TO_W{1'b0}}, 1'b1};

  logic            prev_q;
  logic            present_q;
  logic [TO_W-1:0] cnt_q;
  logic [TO_W:0]   cnt_inc;
  logic            edge_w;

  assign rise_o  = lvl_i & ~prev_q;
  assign fall_o  = ~lvl_i & prev_q;
  assign edge_w  = rise_o | fall_o;
  assign cnt_inc = {1'b0, cnt_q} + CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b0;
      present_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      prev_q <= lvl_i;
      if (edge_w) begin
        // an edge always beats an expiring tick
        present_q <= 1'b1;
        cnt_q     <= '0;
      end else if (tick_i && present_q) begin
        if (cnt_inc >= {1'b0, limit_i}) present_q <= 1'b0;
        else                            cnt_q     <= cnt_inc[TO_W-1:0];
      end
    end
  end

  assign present_o = present_q;

  // R2
  present_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_q) |-> $past(edge_w));
  // R3
  present_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(present_q) |-> ($past(tick_i) && !$past(edge_w)));
  // R4
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> present_q);
endmodule

// File: rtl/sync_det_polarity.sv
module sync_det_polarity #(
  parameter int unsigned RUN_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic clear_i,
  output logic pol_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_ONE = {{(RUN_W-1){1'b0}}, 1'b1};

  logic [RUN_W-1:0] run_q, hi_len_q, lo_len_q;
  logic             hi_vld_q, lo_vld_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      hi_len_q <= '0;
      lo_len_q <= '0;
      hi_vld_q <= 1'b0;
      lo_vld_q <= 1'b0;
      pol_q    <= 1'b0;
    end else begin
      if (rise_i || fall_i)    run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + RUN_ONE;

      if (clear_i) begin
        // stale lengths dropped, decided polarity kept
        hi_vld_q <= 1'b0;
        lo_vld_q <= 1'b0;
      end else if (fall_i) begin
        hi_len_q <= run_q;
        hi_vld_q <= 1'b1;
        if (lo_vld_q) pol_q <= (run_q < lo_len_q);
      end else if (rise_i) begin
        lo_len_q <= run_q;
        lo_vld_q <= 1'b1;
        if (hi_vld_q) pol_q <= (hi_len_q < run_q);
      end
    end
  end

  assign pol_o = pol_q;

  // R6
  pol_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pol_q) |-> $past(rise_i || fall_i));
  // R7
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> $stable(pol_q));
endmodule

// File: rtl/sync_det_state.sv
module sync_det_state
  import sync_det_pkg::*;
(
  input  logic       h_present_i,
  input  logic       v_present_i,
  output pwr_state_e state_o
);
  always_comb begin
    unique case ({h_present_i, v_present_i})
      2'b11:   state_o = PWR_NORMAL;
      2'b01:   state_o = PWR_STANDBY;
      2'b10:   state_o = PWR_SUSPEND;
      default: state_o = PWR_OFF;
    endcase
  end
endmodule

// File: rtl/sync_power_det.sv
module sync_power_det
  import sync_det_pkg::*;
#(
  parameter int unsigned TO_W  = 16,
  parameter int unsigned RUN_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            hsync_i,
  input  logic            vsync_i,
  input  logic [TO_W-1:0] h_limit_i,
  input  logic [TO_W-1:0] v_limit_i,
  output logic [7:0]      status_o
);
  logic [NUM_CH-1:0] raw_w, lvl_w, rise_w, fall_w, pres_w, pol_w;
  logic [TO_W-1:0]   limit_w [NUM_CH];
  pwr_state_e        state_w;

  assign raw_w[CH_H]   = hsync_i;
  assign raw_w[CH_V]   = vsync_i;
  assign limit_w[CH_H] = h_limit_i;
  assign limit_w[CH_V] = v_limit_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sync_det_sync2 u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[c]),
      .q_o   (lvl_w[c])
    );

    sync_det_presence #(.TO_W(TO_W)) u_pres (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .lvl_i    (lvl_w[c]),
      .limit_i  (limit_w[c]),
      .rise_o   (rise_w[c]),
      .fall_o   (fall_w[c]),
      .present_o(pres_w[c])
    );

    sync_det_polarity #(.RUN_W(RUN_W)) u_pol (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise_w[c]),
      .fall_i (fall_w[c]),
      .clear_i(~pres_w[c]),
      .pol_o  (pol_w[c])
    );
  end

  sync_det_state u_state (
    .h_present_i(pres_w[CH_H]),
    .v_present_i(pres_w[CH_V]),
    .state_o    (state_w)
  );

  assign status_o = {2'b00, state_w, pol_w[CH_V], pol_w[CH_H], pres_w[CH_V], pres_w[CH_H]};

  // R5
  state_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pres_w[CH_H] && !pres_w[CH_V]) |-> (state_w == PWR_OFF));
  // R5
  state_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == PWR_NORMAL) |-> (pres_w[CH_H] && pres_w[CH_V]));
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o[7:6]) == 0);
endmodule

// File: tb/tb_sync_power_det.sv
module tb_sync_power_det;
  localparam int unsigned TO_W = 16;
  localparam int unsigned LIM  = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tick_i = 1'b0;
  logic            hsync_i = 1'b0;
  logic            vsync_i = 1'b0;
  logic [TO_W-1:0] h_limit_i = TO_W'(LIM);
  logic [TO_W-1:0] v_limit_i = TO_W'(LIM);
  logic [7:0]      status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sync_power_det #(.TO_W(TO_W), .RUN_W(16)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .hsync_i  (hsync_i),
    .vsync_i  (vsync_i),
    .h_limit_i(h_limit_i),
    .v_limit_i(v_limit_i),
    .status_o (status_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_once();
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit hp, vp, hpol, vpol;
    bit exp_hpol, exp_vpol;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset status", status_o, 8'h30);

    // R2: exact latency of presence
    hsync_i = 1'b1;
    cyc(); cyc();
    check("R2 present not before third edge", status_o[0], 0);
    cyc();
    check("R2 present on third edge", status_o[0], 1);
    check("R5 suspend code", status_o[5:4], 2);
    check("R8 vertical untouched", status_o[1], 0);

    // R3: timeout boundary
    for (int k = 0; k < LIM - 1; k++) tick_once();
    check("R3 present after limit-1 ticks", status_o[0], 1);
    tick_once();
    check("R3 absent on limit-th tick", status_o[0], 0);
    check("R5 off code", status_o[5:4], 3);

    // R4: edge and expiring tick in the same cycle
    hsync_i = 1'b0;
    cyc(); cyc(); cyc();
    check("R4 re-present", status_o[0], 1);
    for (int k = 0; k < LIM - 1; k++) tick_once();
    hsync_i = 1'b1;
    cyc(); cyc();
    tick_once();
    check("R4 edge beats expiring tick", status_o[0], 1);
    for (int k = 0; k < LIM - 1; k++) tick_once();
    check("R4 timeout restarted, limit-1 ticks", status_o[0], 1);
    tick_once();
    check("R3 absent after full limit", status_o[0], 0);

    // restart from a known polarity
    rst_ni = 1'b0;
    hsync_i = 1'b0;
    vsync_i = 1'b0;
    cyc();
    rst_ni = 1'b1;
    cyc();
    check("R1 reset status again", status_o, 8'h30);
    exp_hpol = 1'b0;
    exp_vpol = 1'b0;

    // R5/R6/R7/R8 sweep over presence and polarity of both inputs
    for (int i = 0; i < 16; i++) begin
      hp   = i[0];
      vp   = i[1];
      hpol = i[2];
      vpol = i[3];
      for (int c = 0; c < 200; c++) begin
        hsync_i = hp ? (((c % 8) < 2) ? hpol : ~hpol) : ~exp_hpol;
        vsync_i = vp ? (((c % 12) < 3) ? vpol : ~vpol) : ~exp_vpol;
        tick_i  = ((c % 4) == 3);
        cyc();
      end
      tick_i = 1'b0;
      if (hp) exp_hpol = hpol;
      if (vp) exp_vpol = vpol;
      check($sformatf("R8 h present combo %0d", i), status_o[0], hp);
      check($sformatf("R8 v present combo %0d", i), status_o[1], vp);
      check($sformatf("R5 state combo %0d", i), status_o[5:4], {~vp, ~hp});
      check($sformatf("%s h polarity combo %0d", hp ? "R6" : "R7", i), status_o[2], exp_hpol);
      check($sformatf("%s v polarity combo %0d", vp ? "R6" : "R7", i), status_o[3], exp_vpol);
      check($sformatf("R1 reserved bits combo %0d", i), status_o[7:6], 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule